// File: doc/BRIEF.md
# Capture Command Packet Parser

This block sits behind a host-to-device byte FIFO of a logic-analyser front end. It scans the incoming bytes for a two-byte frame header, collects the 82 bytes that follow into a staging store, and, once the last byte of the frame has arrived, looks at the two-byte command at the end of the frame. A start command checks the requested capture depths. If they are legal, it copies the staged fields into the configuration outputs in one cycle and pulses a start strobe. A status or data command only pulses its own strobe. Any other command code has no effect.

The byte input uses a valid/ready handshake. A byte is taken on a rising clock edge when `s_valid` and `s_ready` are both high. `s_ready` is high whenever `restart` is low, so the parser never back-pressures the FIFO during normal operation. While `restart` is high, `s_ready` is low and no byte is taken. The sender may hold `s_valid` across that time and may insert idle cycles anywhere. Multi-byte fields arrive least significant byte first.

The configuration outputs hold their values until the next accepted start frame, until `restart`, or until reset. The rate code is also decoded into external-clock selection pins. The trigger-flag byte is also decoded into trigger-enable and combine pins.

Top module: `cap_cmd_parser`

## Requirements
- R1: A frame begins with byte 0x7F followed directly by byte 0x01. Bytes before this pair are discarded, and a 0x7F that repeats while the header is awaited still counts as the start of the pair.
- R2: After the header, byte positions 2..83 are laid out as follows:
  - 2: rate code
  - 3: trigger flags
  - 4-5: PWM word A
  - 6-7: PWM word B
  - 8: auxiliary byte
  - 9: spare byte
  - 10-13: sample depth
  - 14-17: pretrigger depth
  - 18-49: trigger record 1
  - 50-81: trigger record 2
  - 82-83: command

  Each multi-byte field is little-endian. Each trigger record is eight dwords, with dword k at bits [32k+31:32k].
- R3: When the command bytes are 0x1A then 0x2B and the depths are legal, every configuration output takes the frame's values, and `start_pulse` is high for one cycle. Both happen in the cycle after the final byte is accepted.
- R4: Command bytes 0x3A,0x4B pulse `status_pulse`. Command bytes 0x5A,0x6B pulse `data_pulse`. Neither changes any configuration output. Any other command pair causes no strobe and no change.
- R5: Depths are legal only when the sample depth is between 2048 and 67108864 inclusive, the sample depth is a multiple of 512, and the pretrigger depth is below the sample depth. A start frame with illegal depths sets `param_error`, leaves the configuration unchanged and gives no `start_pulse`.
- R6: `param_error` stays high through later frames of any kind until `restart` or reset.
- R7: Reset, or `restart` high at a clock edge, clears every configuration output and `param_error`, and returns the parser to waiting for a header.
- R8: Configuration outputs do not change while a frame is incomplete. A frame cut short leaves the previous configuration in place.
- R9: Rate code 0x24 selects an external clock on line A, rising edge, and 0x25 selects line B, rising edge. Codes 0x28 and 0x29 select the falling edge on A and B, and codes 0x26 and 0x27 select both edges on A and B. `clk_edge` encodes rising as 0, falling as 1 and both as 2. Every other code gives `clk_ext`=0, `clk_use_b`=0 and `clk_edge`=0.
- R10: Bits of the trigger-flag byte drive the trigger pins: `trig1_en` is bit 0, `trig2_en` is bit 1, and `trig_and` is bit 2. A value of 1 on `trig_and` means AND and 0 means OR.
- R11: `s_ready` is the inverse of `restart`. A byte counts only when `s_valid` and `s_ready` are both high at a clock edge.
- R12: Each strobe lasts one cycle, and at most one of `start_pulse`, `status_pulse` and `data_pulse` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Clears parser and configuration |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_ready | output | 1 | Parser accepts a byte |
| rate_code | output | 8 | Latched sample-rate code |
| trig_flags | output | 8 | Latched trigger-flag byte |
| pwm_a | output | 16 | Threshold PWM word, group A |
| pwm_b | output | 16 | Threshold PWM word, group B |
| aux_byte | output | 8 | Latched auxiliary byte |
| spare_byte | output | 8 | Latched spare byte |
| sample_depth | output | 32 | Samples per channel |
| pretrig_depth | output | 32 | Samples before trigger |
| trig1_cfg | output | 256 | Trigger record 1, eight dwords |
| trig2_cfg | output | 256 | Trigger record 2, eight dwords |
| trig1_en | output | 1 | Trigger 1 enabled |
| trig2_en | output | 1 | Trigger 2 enabled |
| trig_and | output | 1 | Trigger combine: 1 AND, 0 OR |
| clk_ext | output | 1 | External sampling clock selected |
| clk_use_b | output | 1 | External clock line B selected |
| clk_edge | output | 2 | External clock edge: 0 rise, 1 fall, 2 both |
| start_pulse | output | 1 | One-cycle start-capture strobe |
| status_pulse | output | 1 | One-cycle get-status strobe |
| data_pulse | output | 1 | One-cycle get-data strobe |
| param_error | output | 1 | Sticky illegal-depth flag |

## Verification
The case that matters is `restart` landing in the same cycle as the final command byte of a legal start frame. At that moment the commit and the clear compete for the same registers. The bench provokes it by sending 83 bytes of a start frame, then raising `s_valid` with the last byte and `restart` together for one cycle. It judges the result by expecting no start strobe, all configuration at zero and `s_ready` low in that cycle. It then expects a complete frame sent straight afterwards to be parsed from its header. The bench's reference model applies restart before byte acceptance, and its per-clock comparison flags any output that disagrees.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  // Frame length including two header bytes
  localparam int FRAME_BYTES = 84;
  // Staging slots cover byte positions 2..82; position 83 is taken live
  localparam int SLOT_BASE   = 2;
  localparam int SLOTS       = FRAME_BYTES - SLOT_BASE - 1;

  // Slot offsets (slot = byte position - SLOT_BASE)
  localparam int SL_RATE   = 0;
  localparam int SL_TFLAG  = 1;
  localparam int SL_PWMA   = 2;
  localparam int SL_PWMB   = 4;
  localparam int SL_AUX    = 6;
  localparam int SL_SPARE  = 7;
  localparam int SL_DEPTH  = 8;
  localparam int SL_PRE    = 12;
  localparam int SL_TRIG1  = 16;
  localparam int SL_TRIG2  = 48;
  localparam int SL_CMD0   = 80;
  localparam int TRIG_BITS = 256;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } clk_edge_e;
endpackage

// File: rtl/ccp_framer.sv
module ccp_framer #(
  parameter int          FRAME_BYTES = 84,
  parameter int          PW          = 7,
  parameter logic [7:0]  MAGIC0      = 8'h7F,
  parameter logic [7:0]  MAGIC1      = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          fire,
  input  logic [7:0]    din,
  output logic [PW-1:0] pos,
  output logic          frame_done
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pos <= '0;
    end else if (fire) begin
      if (pos == PW'(0)) begin
        pos <= (din == MAGIC0) ? PW'(1) : PW'(0);
      end else if (pos == PW'(1)) begin
        if (din == MAGIC1)      pos <= PW'(2);
        else if (din == MAGIC0) pos <= PW'(1);
        else                    pos <= PW'(0);
      end else if (pos == LAST) begin
        pos <= '0;
      end else begin
        pos <= pos + PW'(1);
      end
    end
  end

  assign frame_done = fire && (pos == LAST);

  // R1: position never leaves the frame
  a_r1_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);
  // R1: a wrong second header byte never opens the body
  a_r1_header_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !restart && pos == PW'(1) && din != MAGIC1) |=> (pos <= PW'(1)));
endmodule

// File: rtl/ccp_stage.sv
module ccp_stage #(
  parameter int SLOTS     = 81,
  parameter int SLOT_BASE = 2,
  parameter int PW        = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               fire,
  input  logic [PW-1:0]      pos,
  input  logic [7:0]         din,
  output logic [SLOTS*8-1:0] staged
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n || restart)                        q <= '0;
      else if (fire && pos == PW'(s + SLOT_BASE))   q <= din;
    end
    assign staged[s*8 +: 8] = q;
  end
endmodule

// File: rtl/ccp_depth_check.sv
module ccp_depth_check #(
  parameter int unsigned DEPTH_MIN  = 2048,
  parameter int unsigned DEPTH_MAX  = 67108864,
  parameter int          ALIGN_LOG2 = 9
) (
  input  logic [31:0] depth,
  input  logic [31:0] pre,
  output logic        legal
);
  logic in_range, aligned, pre_ok;
  always_comb begin
    in_range = (depth >= DEPTH_MIN) && (depth <= DEPTH_MAX);
    aligned  = (depth[ALIGN_LOG2-1:0] == '0);
    pre_ok   = (pre < depth);
    legal    = in_range && aligned && pre_ok;
  end
endmodule

// File: rtl/ccp_rate_decode.sv
module ccp_rate_decode
  import ccp_pkg::*;
(
  input  logic [7:0] code,
  output logic       ext,
  output logic       use_b,
  output logic [1:0] edge_sel
);
  clk_edge_e e;
  always_comb begin
    ext   = 1'b1;
    use_b = code[0];
    e     = EDGE_RISE;
    case (code)
      8'h24, 8'h25: e = EDGE_RISE;
      8'h28, 8'h29: e = EDGE_FALL;
      8'h26, 8'h27: e = EDGE_BOTH;
      default: begin
        ext   = 1'b0;
        use_b = 1'b0;
      end
    endcase
    edge_sel = e;
  end
endmodule

// File: rtl/cap_cmd_parser.sv
module cap_cmd_parser
  import ccp_pkg::*;
#(
  parameter logic [7:0]  MAGIC0     = 8'h7F,
  parameter logic [7:0]  MAGIC1     = 8'h01,
  parameter logic [15:0] CMD_START  = 16'h2B1A,
  parameter logic [15:0] CMD_STATUS = 16'h4B3A,
  parameter logic [15:0] CMD_DATA   = 16'h6B5A,
  parameter int unsigned DEPTH_MIN  = 2048,
  parameter int unsigned DEPTH_MAX  = 67108864,
  parameter int          ALIGN_LOG2 = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         s_valid,
  input  logic [7:0]   s_data,
  output logic         s_ready,
  output logic [7:0]   rate_code,
  output logic [7:0]   trig_flags,
  output logic [15:0]  pwm_a,
  output logic [15:0]  pwm_b,
  output logic [7:0]   aux_byte,
  output logic [7:0]   spare_byte,
  output logic [31:0]  sample_depth,
  output logic [31:0]  pretrig_depth,
  output logic [255:0] trig1_cfg,
  output logic [255:0] trig2_cfg,
  output logic         trig1_en,
  output logic         trig2_en,
  output logic         trig_and,
  output logic         clk_ext,
  output logic         clk_use_b,
  output logic [1:0]   clk_edge,
  output logic         start_pulse,
  output logic         status_pulse,
  output logic         data_pulse,
  output logic         param_error
);
  localparam int PW = $clog2(FRAME_BYTES);

  logic               fire;
  logic [PW-1:0]      pos;
  logic               frame_done;
  logic [SLOTS*8-1:0] staged;
  logic               depth_legal;
  logic [15:0]        cmd;

  assign s_ready = !restart;
  assign fire    = s_valid && s_ready;

  ccp_framer #(
    .FRAME_BYTES(FRAME_BYTES), .PW(PW), .MAGIC0(MAGIC0), .MAGIC1(MAGIC1)
  ) framer_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .fire(fire),
    .din(s_data), .pos(pos), .frame_done(frame_done)
  );

  ccp_stage #(
    .SLOTS(SLOTS), .SLOT_BASE(SLOT_BASE), .PW(PW)
  ) stage_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .fire(fire),
    .pos(pos), .din(s_data), .staged(staged)
  );

  ccp_depth_check #(
    .DEPTH_MIN(DEPTH_MIN), .DEPTH_MAX(DEPTH_MAX), .ALIGN_LOG2(ALIGN_LOG2)
  ) check_i (
    .depth(staged[SL_DEPTH*8 +: 32]), .pre(staged[SL_PRE*8 +: 32]),
    .legal(depth_legal)
  );

  ccp_rate_decode rate_i (
    .code(rate_code), .ext(clk_ext), .use_b(clk_use_b), .edge_sel(clk_edge)
  );

  assign trig1_en = trig_flags[0];
  assign trig2_en = trig_flags[1];
  assign trig_and = trig_flags[2];

  // command: first byte from staging, second byte arriving now
  assign cmd = {s_data, staged[SL_CMD0*8 +: 8]};

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      rate_code     <= '0;
      trig_flags    <= '0;
      pwm_a         <= '0;
      pwm_b         <= '0;
      aux_byte      <= '0;
      spare_byte    <= '0;
      sample_depth  <= '0;
      pretrig_depth <= '0;
      trig1_cfg     <= '0;
      trig2_cfg     <= '0;
      start_pulse   <= 1'b0;
      status_pulse  <= 1'b0;
      data_pulse    <= 1'b0;
      param_error   <= 1'b0;
    end else begin
      start_pulse  <= 1'b0;
      status_pulse <= 1'b0;
      data_pulse   <= 1'b0;
      if (frame_done) begin
        if (cmd == CMD_START) begin
          if (depth_legal) begin
            rate_code     <= staged[SL_RATE*8  +: 8];
            trig_flags    <= staged[SL_TFLAG*8 +: 8];
            pwm_a         <= staged[SL_PWMA*8  +: 16];
            pwm_b         <= staged[SL_PWMB*8  +: 16];
            aux_byte      <= staged[SL_AUX*8   +: 8];
            spare_byte    <= staged[SL_SPARE*8 +: 8];
            sample_depth  <= staged[SL_DEPTH*8 +: 32];
            pretrig_depth <= staged[SL_PRE*8   +: 32];
            trig1_cfg     <= staged[SL_TRIG1*8 +: TRIG_BITS];
            trig2_cfg     <= staged[SL_TRIG2*8 +: TRIG_BITS];
            start_pulse   <= 1'b1;
          end else begin
            param_error   <= 1'b1;
          end
        end else if (cmd == CMD_STATUS) begin
          status_pulse <= 1'b1;
        end else if (cmd == CMD_DATA) begin
          data_pulse <= 1'b1;
        end
      end
    end
  end

  // R12: strobes are mutually exclusive
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, status_pulse, data_pulse}));
  // R12: start strobe lasts one cycle
  a_r12_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  // R5: a start is only seen with legal committed depths
  a_r5_start_legal: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (sample_depth >= DEPTH_MIN && sample_depth <= DEPTH_MAX
                     && pretrig_depth < sample_depth));
  // R6: error flag holds until restart
  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (param_error && !restart) |=> param_error);
  // R7: restart clears error and configuration
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!param_error && !start_pulse && sample_depth == '0));
  // R4: status and data strobes leave configuration untouched
  a_r4_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (status_pulse || data_pulse) |-> ($stable(sample_depth) && $stable(rate_code)
                                      && $stable(trig1_cfg)));
endmodule

// File: tb/cap_cmd_parser_tb_top.sv
module cap_cmd_parser_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0, restart = 1'b0, s_valid = 1'b0;
  logic [7:0]   s_data = '0;
  logic         s_ready;
  logic [7:0]   rate_code, trig_flags, aux_byte, spare_byte;
  logic [15:0]  pwm_a, pwm_b;
  logic [31:0]  sample_depth, pretrig_depth;
  logic [255:0] trig1_cfg, trig2_cfg;
  logic         trig1_en, trig2_en, trig_and, clk_ext, clk_use_b;
  logic [1:0]   clk_edge;
  logic         start_pulse, status_pulse, data_pulse, param_error;

  cap_cmd_parser dut_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .rate_code(rate_code), .trig_flags(trig_flags), .pwm_a(pwm_a),
    .pwm_b(pwm_b), .aux_byte(aux_byte), .spare_byte(spare_byte),
    .sample_depth(sample_depth), .pretrig_depth(pretrig_depth), .trig1_cfg(trig1_cfg),
    .trig2_cfg(trig2_cfg), .trig1_en(trig1_en), .trig2_en(trig2_en), .trig_and(trig_and),
    .clk_ext(clk_ext), .clk_use_b(clk_use_b), .clk_edge(clk_edge),
    .start_pulse(start_pulse), .status_pulse(status_pulse), .data_pulse(data_pulse),
    .param_error(param_error)
  );

  int checks = 0, failures = 0;
  int n_start = 0, n_stat = 0, n_data = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_pos = 0;
  logic [7:0]  m_pkt [84];
  logic [7:0]  e_rate = 0, e_tf = 0, e_aux = 0, e_spare = 0;
  logic [15:0] e_pa = 0, e_pb = 0;
  logic [31:0] e_depth = 0, e_pre = 0;
  logic [255:0] e_t1 = 0, e_t2 = 0;
  bit          e_start = 0, e_stat = 0, e_data = 0, e_err = 0;

  function automatic logic [31:0] le32(input int off);
    return {m_pkt[off+3], m_pkt[off+2], m_pkt[off+1], m_pkt[off]};
  endfunction

  function automatic logic [3:0] clk_model(input logic [7:0] r);
    case (r)
      8'h24: return 4'b1000;
      8'h25: return 4'b1100;
      8'h28: return 4'b1001;
      8'h29: return 4'b1101;
      8'h26: return 4'b1010;
      8'h27: return 4'b1110;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic model_frame_end();
    logic [31:0] d, p;
    bit legal;
    d = le32(10);
    p = le32(14);
    legal = (d >= 32'd2048) && (d <= 32'd67108864) && (d % 512 == 0) && (p < d);
    if (m_pkt[82] == 8'h1A && m_pkt[83] == 8'h2B) begin
      if (legal) begin
        e_rate = m_pkt[2]; e_tf = m_pkt[3];
        e_pa = {m_pkt[5], m_pkt[4]}; e_pb = {m_pkt[7], m_pkt[6]};
        e_aux = m_pkt[8]; e_spare = m_pkt[9];
        e_depth = d; e_pre = p;
        for (int k = 0; k < 32; k++) begin
          e_t1[k*8 +: 8] = m_pkt[18+k];
          e_t2[k*8 +: 8] = m_pkt[50+k];
        end
        e_start = 1;
      end else e_err = 1;
    end else if (m_pkt[82] == 8'h3A && m_pkt[83] == 8'h4B) e_stat = 1;
    else if (m_pkt[82] == 8'h5A && m_pkt[83] == 8'h6B) e_data = 1;
  endtask

  always @(posedge clk) begin
    e_start = 0; e_stat = 0; e_data = 0;
    if (!rst_n || restart) begin
      m_pos = 0; e_rate = 0; e_tf = 0; e_pa = 0; e_pb = 0; e_aux = 0; e_spare = 0;
      e_depth = 0; e_pre = 0; e_t1 = 0; e_t2 = 0; e_err = 0;
    end else if (s_valid) begin
      if (m_pos == 0) m_pos = (s_data == 8'h7F) ? 1 : 0;
      else if (m_pos == 1) m_pos = (s_data == 8'h01) ? 2 : ((s_data == 8'h7F) ? 1 : 0);
      else begin
        m_pkt[m_pos] = s_data;
        if (m_pos == 83) begin
          model_frame_end();
          m_pos = 0;
        end else m_pos++;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(s_ready == !restart, "R11 s_ready", s_ready, !restart);
      chk({rate_code, trig_flags, pwm_a, pwm_b, aux_byte, spare_byte} ==
          {e_rate, e_tf, e_pa, e_pb, e_aux, e_spare}, "R2 header fields",
          {rate_code, trig_flags, pwm_a, pwm_b, aux_byte, spare_byte},
          {e_rate, e_tf, e_pa, e_pb, e_aux, e_spare});
      chk({sample_depth, pretrig_depth} == {e_depth, e_pre}, "R2 depths",
          {sample_depth, pretrig_depth}, {e_depth, e_pre});
      chk(trig1_cfg == e_t1, "R2 trigger record 1", trig1_cfg, e_t1);
      chk(trig2_cfg == e_t2, "R2 trigger record 2", trig2_cfg, e_t2);
      chk(start_pulse == e_start, "R3 start strobe", start_pulse, e_start);
      chk({status_pulse, data_pulse} == {e_stat, e_data}, "R4 status/data strobes",
          {status_pulse, data_pulse}, {e_stat, e_data});
      chk(param_error == e_err, "R5 param_error", param_error, e_err);
      chk({clk_ext, clk_use_b, clk_edge} == clk_model(e_rate), "R9 clock decode",
          {clk_ext, clk_use_b, clk_edge}, clk_model(e_rate));
      chk({trig1_en, trig2_en, trig_and} == {e_tf[0], e_tf[1], e_tf[2]}, "R10 trigger pins",
          {trig1_en, trig2_en, trig_and}, {e_tf[0], e_tf[1], e_tf[2]});
      chk($countones({start_pulse, status_pulse, data_pulse}) <= 1, "R12 strobe exclusivity",
          {start_pulse, status_pulse, data_pulse}, 0);
      if (start_pulse)  n_start++;
      if (status_pulse) n_stat++;
      if (data_pulse)   n_data++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input logic [7:0] b);
    s_valid = 1'b1;
    s_data  = b;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] rate, input logic [7:0] tf, input logic [15:0] pa,
                      input logic [15:0] pb, input logic [31:0] dep, input logic [31:0] pre,
                      input logic [7:0] seed, input logic [15:0] cmd, input int nb);
    logic [7:0] p [84];
    p[0] = 8'h7F; p[1] = 8'h01; p[2] = rate; p[3] = tf;
    p[4] = pa[7:0]; p[5] = pa[15:8]; p[6] = pb[7:0]; p[7] = pb[15:8];
    p[8] = seed ^ 8'hA5; p[9] = seed;
    for (int k = 0; k < 4; k++) begin
      p[10+k] = dep[k*8 +: 8];
      p[14+k] = pre[k*8 +: 8];
    end
    for (int k = 0; k < 64; k++) p[18+k] = seed + 8'(k);
    p[82] = cmd[7:0]; p[83] = cmd[15:8];
    for (int i = 0; i < nb; i++) put(p[i]);
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b0, "R11 ready low in restart", s_ready, 0);
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
    chk(sample_depth == 0 && param_error == 0, "R7 restart clears",
        {sample_depth, param_error}, 0);
  endtask

  localparam logic [15:0] C_START = 16'h2B1A, C_STAT = 16'h4B3A, C_DATA = 16'h6B5A;

  initial begin
    int s0;
    logic [3:0] cm;
    gap(2);
    cmp_on = 1'b1;
    gap(1);
    chk(sample_depth == 0 && !param_error && !start_pulse && rate_code == 0,
        "R7 reset state", {sample_depth, param_error, start_pulse}, 0);
    rst_n = 1'b1;
    gap(1);

    // R1: garbage then a repeated 0x7F before the header
    put(8'h00); put(8'h7F); put(8'h55); put(8'h7F);
    send(8'h22, 8'h03, 16'h0ABC, 16'h0123, 32'd4096, 32'd100, 8'h10, C_START, 84);
    gap(1);
    chk(n_start == 1, "R1/R3 start after resync", n_start, 1);
    chk(sample_depth == 32'd4096 && pretrig_depth == 32'd100, "R2 depth fields",
        {sample_depth, pretrig_depth}, {32'd4096, 32'd100});
    chk(pwm_a == 16'h0ABC && pwm_b == 16'h0123, "R2 pwm words", {pwm_a, pwm_b}, 32'h0ABC0123);
    chk(trig1_cfg[7:0] == 8'h10 && trig2_cfg[255:248] == 8'h4F, "R2 trigger byte order",
        {trig1_cfg[7:0], trig2_cfg[255:248]}, 16'h104F);
    chk(clk_ext == 0 && trig1_en && trig2_en && !trig_and, "R10 flags 0x03",
        {clk_ext, trig1_en, trig2_en, trig_and}, 4'b0110);

    // R4: status, data and unknown commands
    send(8'h00, 8'h00, 16'h1111, 16'h2222, 32'd8192, 32'd0, 8'h20, C_STAT, 84);
    gap(1);
    chk(n_stat == 1 && sample_depth == 32'd4096, "R4 status keeps config",
        {n_stat, sample_depth}, {32'd1, 32'd4096});
    send(8'h00, 8'h00, 16'h1111, 16'h2222, 32'd8192, 32'd0, 8'h30, C_DATA, 84);
    gap(1);
    chk(n_data == 1 && pwm_a == 16'h0ABC, "R4 data keeps config", {n_data, pwm_a}, {32'd1, 16'h0ABC});
    send(8'h00, 8'h00, 16'h1111, 16'h2222, 32'd2048, 32'd0, 8'h40, 16'h2211, 84);
    gap(1);
    chk(n_start == 1 && n_stat == 1 && n_data == 1 && sample_depth == 32'd4096,
        "R4 unknown command ignored", {n_start, n_stat, n_data}, {32'd1, 32'd1, 32'd1});

    // R5 / R6: illegal depth, then error survives a status frame
    send(8'h01, 8'h01, 16'h0001, 16'h0002, 32'd1000, 32'd0, 8'h50, C_START, 84);
    gap(1);
    chk(param_error && n_start == 1 && sample_depth == 32'd4096, "R5 small depth rejected",
        {param_error, sample_depth}, {1'b1, 32'd4096});
    send(8'h00, 8'h00, 16'h0, 16'h0, 32'd4096, 32'd0, 8'h60, C_STAT, 84);
    gap(1);
    chk(param_error && n_stat == 2, "R6 error sticky", {param_error, n_stat}, {1'b1, 32'd2});
    do_restart();

    // R5 boundaries
    send(8'h00, 8'h00, 16'h0, 16'h0, 32'd2048, 32'd2047, 8'h70, C_START, 84);
    gap(1);
    chk(n_start == 2 && !param_error && sample_depth == 32'd2048, "R5 minimum legal",
        {n_start, sample_depth}, {32'd2, 32'd2048});
    send(8'h00, 8'h00, 16'h0, 16'h0, 32'd67108864, 32'd0, 8'h71, C_START, 84);
    gap(1);
    chk(n_start == 3 && sample_depth == 32'd67108864, "R5 maximum legal",
        {n_start, sample_depth}, {32'd3, 32'd67108864});
    send(8'h00, 8'h00, 16'h0, 16'h0, 32'd2304, 32'd0, 8'h72, C_START, 84);
    gap(1);
    chk(param_error && n_start == 3, "R5 unaligned depth", {param_error, n_start}, {1'b1, 32'd3});
    do_restart();
    send(8'h00, 8'h00, 16'h0, 16'h0, 32'd67109376, 32'd0, 8'h73, C_START, 84);
    gap(1);
    chk(param_error && n_start == 3, "R5 depth above max", {param_error, n_start}, {1'b1, 32'd3});
    do_restart();
    send(8'h00, 8'h00, 16'h0, 16'h0, 32'd4096, 32'd4096, 8'h74, C_START, 84);
    gap(1);
    chk(param_error && n_start == 3, "R5 pretrigger equal depth", {param_error, n_start}, {1'b1, 32'd3});
    do_restart();

    // R8: truncated frame
    send(8'h24, 8'h05, 16'h0, 16'h0, 32'd8192, 32'd10, 8'h80, C_START, 84);
    gap(1);
    send(8'h25, 8'h00, 16'h0, 16'h0, 32'd16384, 32'd10, 8'h81, C_START, 40);
    gap(3);
    chk(sample_depth == 32'd8192 && rate_code == 8'h24, "R8 truncated keeps config",
        {sample_depth, rate_code}, {32'd8192, 8'h24});
    chk(trig1_en && !trig2_en && trig_and, "R10 flags 0x05", {trig1_en, trig2_en, trig_and}, 3'b101);
    do_restart();

    // R9: external clock codes
    for (int c = 8'h24; c <= 8'h29; c++) begin
      send(8'(c), 8'h00, 16'h0, 16'h0, 32'd2048, 32'd0, 8'(c), C_START, 84);
      gap(1);
      cm = clk_model(8'(c));
      chk({clk_ext, clk_use_b, clk_edge} == cm, "R9 external clock decode",
          {clk_ext, clk_use_b, clk_edge}, cm);
    end

    // R7 with R11: restart in the same cycle as the final byte
    do_restart();
    s0 = n_start;
    send(8'h22, 8'h01, 16'h0, 16'h0, 32'd16384, 32'd5, 8'h90, C_START, 83);
    s_valid = 1'b1; s_data = 8'h2B; restart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0; restart = 1'b0;
    gap(2);
    chk(n_start == s0 && sample_depth == 0, "R7 restart beats final byte",
        {n_start, sample_depth}, {s0, 32'd0});
    send(8'h22, 8'h01, 16'h0, 16'h0, 32'd16384, 32'd5, 8'h91, C_START, 84);
    gap(1);
    chk(n_start == s0 + 1 && sample_depth == 32'd16384, "R1 aligned after restart",
        {n_start, sample_depth}, {s0 + 1, 32'd16384});

    gap(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule